// File: doc/BRIEF.md
# Inbound Transaction Address Decoder

This block sits behind a downstream I/O link and classifies every inbound request before it travels further into the chip. Each request carries an address, a memory-or-I/O flag and a read-or-write flag, and arrives with a valid/ready handshake. The block compares the address against software-programmed windows, applies a fixed priority with legacy overrides, and produces one routing decision per request.

The possible destinations are system memory (with a coherent or non-coherent attribute), local peer-to-peer, the legacy VGA memory agent, the legacy VGA I/O agent, the subtractive port, completer abort, or an error. The decision is registered and offered on a response channel with its own valid/ready pair. All window registers are plain inputs, sampled in the cycle a request is accepted. The second-stage per-socket decode and the movement of payload data happen elsewhere.

Top module: `inbound_route_decoder`

## Requirements
- R1: A memory request whose address is at or above `cfg_phys_limit` is routed to ERROR (code 6), ahead of every other rule; I/O requests never take this path.
- R2: A memory request inside any protected window is routed to ABORT (code 5), unless it also lies inside one of the management windows, in which case it continues through the remaining rules.
- R3: Memory addresses 0xA0000 to 0xBFFFF inclusive are routed to VGA_MEM (code 2), even when they lie inside a system memory window.
- R4: An I/O request whose low 16 address bits fall in 0x3B0–0x3BB or 0x3C0–0x3DF is routed to VGA_IO (code 3); the upper address bits play no part, and every other I/O request is routed to SUBTR (code 4).
- R5: A memory request in the low window [0, `cfg_tolm`) or the high window [4 GB, `cfg_tohm`) is routed to MEM (code 0); `cfg_tolm` must not exceed 4 GB so the two windows never overlap.
- R6: A MEM result whose address also lies in [`cfg_nc_base`, `cfg_nc_limit`) carries `rsp_noncoh`=1; every other result carries `rsp_noncoh`=0.
- R7: A memory request in [`cfg_peer_base`, `cfg_peer_limit`) that matched no earlier rule is routed to PEER (code 1) when it is a write and to ABORT (code 5) when it is a read.
- R8: A memory request that matches no rule above is routed to SUBTR (code 4).
- R9: Every window includes its base and excludes its limit; a window whose limit is less than or equal to its base matches nothing.
- R10: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high; its decision appears with `rsp_valid` high in the following cycle and stays unchanged until a clock edge with `rsp_ready` high; `req_ready` is low whenever `rsp_valid` is high and `rsp_ready` is low.
- R11: After reset `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Request address |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_is_write | input | 1 | 1 = write, 0 = read |
| cfg_phys_limit | input | ADDR_W | Top of the physical address space (exclusive) |
| cfg_tolm | input | ADDR_W | Limit of the low memory window |
| cfg_tohm | input | ADDR_W | Limit of the high memory window |
| cfg_nc_base | input | ADDR_W | Base of the non-coherent sub-window |
| cfg_nc_limit | input | ADDR_W | Limit of the non-coherent sub-window |
| cfg_peer_base | input | ADDR_W | Base of the local peer window |
| cfg_peer_limit | input | ADDR_W | Limit of the local peer window |
| cfg_prot_base | input | PROT_N*ADDR_W | Bases of the protected windows, window k in slice k |
| cfg_prot_limit | input | PROT_N*ADDR_W | Limits of the protected windows |
| cfg_mgmt_base | input | MGMT_N*ADDR_W | Bases of the management windows |
| cfg_mgmt_limit | input | MGMT_N*ADDR_W | Limits of the management windows |
| rsp_valid | output | 1 | Decision present |
| rsp_ready | input | 1 | Consumer takes the decision |
| rsp_target | output | 3 | Target code: 0 MEM, 1 PEER, 2 VGA_MEM, 3 VGA_IO, 4 SUBTR, 5 ABORT, 6 ERROR |
| rsp_noncoh | output | 1 | Non-coherent attribute for MEM results |

## Verification
Every cycle the assertions watch the response handshake (one-cycle latency, stable held results, ready withdrawn under stall), that above-limit memory requests end as ERROR, that I/O requests only ever reach VGA_IO or SUBTR, that peer reads never become PEER, and that the non-coherent flag only rides on MEM results. The exact boundaries of each window, the override order between error, abort, legacy VGA and the memory windows, the management exemption and the effect of a disabled window can only be shown by the bench's directed scenarios, which reprogram the windows between phases and run the traffic under random backpressure.

// File: rtl/ird_pkg.sv
package ird_pkg;

  typedef enum logic [2:0] {
    TGT_MEM     = 3'd0,
    TGT_PEER    = 3'd1,
    TGT_VGA_MEM = 3'd2,
    TGT_VGA_IO  = 3'd3,
    TGT_SUBTR   = 3'd4,
    TGT_ABORT   = 3'd5,
    TGT_ERROR   = 3'd6
  } route_e;

  typedef struct packed {
    route_e target;
    logic   noncoh;
  } decision_t;

  // Legacy ranges, inclusive at both ends
  localparam logic [19:0] LEG_MEM_FIRST = 20'hA0000;
  localparam logic [19:0] LEG_MEM_LAST  = 20'hBFFFF;
  localparam logic [15:0] LEG_IO_A_FIRST = 16'h03B0;
  localparam logic [15:0] LEG_IO_A_LAST  = 16'h03BB;
  localparam logic [15:0] LEG_IO_B_FIRST = 16'h03C0;
  localparam logic [15:0] LEG_IO_B_LAST  = 16'h03DF;

endpackage

// File: rtl/ird_rst_sync.sv
module ird_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/ird_window_match.sv
module ird_window_match #(
  parameter int ADDR_W = 40
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output logic              hit
);

  logic enabled;
  logic above_base;
  logic below_limit;

  always_comb begin
    enabled     = (limit > base);
    above_base  = (addr >= base);
    below_limit = (addr < limit);
    hit         = enabled && above_base && below_limit;
  end

endmodule

// File: rtl/ird_classify.sv
module ird_classify
  import ird_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_io,
  input  logic              is_write,
  input  logic              over_limit,
  input  logic              prot_hit,
  input  logic              mgmt_hit,
  input  logic              mem_hit,
  input  logic              nc_hit,
  input  logic              peer_hit,
  output decision_t         decision
);

  localparam logic [ADDR_W-1:0] LEG_LO = ADDR_W'(LEG_MEM_FIRST);
  localparam logic [ADDR_W-1:0] LEG_HI = ADDR_W'(LEG_MEM_LAST);

  logic [15:0] io_port;
  logic        leg_mem_hit;
  logic        leg_io_hit;
  logic        abort_hit;

  always_comb begin
    io_port     = addr[15:0];
    leg_mem_hit = (addr >= LEG_LO) && (addr <= LEG_HI);
    leg_io_hit  = ((io_port >= LEG_IO_A_FIRST) && (io_port <= LEG_IO_A_LAST)) ||
                  ((io_port >= LEG_IO_B_FIRST) && (io_port <= LEG_IO_B_LAST));
    abort_hit   = prot_hit && !mgmt_hit;
  end

  always_comb begin
    decision.target = TGT_SUBTR;
    decision.noncoh = 1'b0;
    if (is_io) begin
      decision.target = leg_io_hit ? TGT_VGA_IO : TGT_SUBTR;
    end else if (over_limit) begin
      decision.target = TGT_ERROR;
    end else if (abort_hit) begin
      decision.target = TGT_ABORT;
    end else if (leg_mem_hit) begin
      decision.target = TGT_VGA_MEM;
    end else if (mem_hit) begin
      decision.target = TGT_MEM;
      decision.noncoh = nc_hit;
    end else if (peer_hit) begin
      decision.target = is_write ? TGT_PEER : TGT_ABORT;
    end else begin
      decision.target = TGT_SUBTR;
    end
  end

endmodule

// File: rtl/ird_out_stage.sv
module ird_out_stage
  import ird_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_valid,
  output logic      in_ready,
  input  decision_t in_data,
  output logic      out_valid,
  input  logic      out_ready,
  output decision_t out_data
);

  logic      valid_q;
  logic      valid_d;
  decision_t data_q;
  logic      load_en;

  always_comb begin
    in_ready = !valid_q || out_ready;
    load_en  = in_valid && in_ready;
    if (load_en) begin
      valid_d = 1'b1;
    end else if (out_ready) begin
      valid_d = 1'b0;
    end else begin
      valid_d = valid_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '{target: TGT_SUBTR, noncoh: 1'b0};
    end else if (load_en) begin
      data_q <= in_data;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R10
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R10

endmodule

// File: rtl/inbound_route_decoder.sv
module inbound_route_decoder
  import ird_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int PROT_N = 2,
  parameter int MGMT_N = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_is_io,
  input  logic                     req_is_write,
  input  logic [ADDR_W-1:0]        cfg_phys_limit,
  input  logic [ADDR_W-1:0]        cfg_tolm,
  input  logic [ADDR_W-1:0]        cfg_tohm,
  input  logic [ADDR_W-1:0]        cfg_nc_base,
  input  logic [ADDR_W-1:0]        cfg_nc_limit,
  input  logic [ADDR_W-1:0]        cfg_peer_base,
  input  logic [ADDR_W-1:0]        cfg_peer_limit,
  input  logic [PROT_N*ADDR_W-1:0] cfg_prot_base,
  input  logic [PROT_N*ADDR_W-1:0] cfg_prot_limit,
  input  logic [MGMT_N*ADDR_W-1:0] cfg_mgmt_base,
  input  logic [MGMT_N*ADDR_W-1:0] cfg_mgmt_limit,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [2:0]               rsp_target,
  output logic                     rsp_noncoh
);

  localparam logic [ADDR_W-1:0] HIGH_BASE = ADDR_W'(64'h1_0000_0000);
  localparam logic [ADDR_W-1:0] ZERO_ADDR = '0;

  logic              rst_sync_n;
  logic              low_hit;
  logic              high_hit;
  logic              nc_win_hit;
  logic              peer_hit;
  logic [PROT_N-1:0] prot_hits;
  logic [MGMT_N-1:0] mgmt_hits;
  logic              over_limit;
  logic              mem_hit;
  decision_t         decision;
  decision_t         rsp_data;

  ird_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ird_window_match #(.ADDR_W(ADDR_W)) u_low_win (
    .addr(req_addr), .base(ZERO_ADDR), .limit(cfg_tolm), .hit(low_hit)
  );
  ird_window_match #(.ADDR_W(ADDR_W)) u_high_win (
    .addr(req_addr), .base(HIGH_BASE), .limit(cfg_tohm), .hit(high_hit)
  );
  ird_window_match #(.ADDR_W(ADDR_W)) u_nc_win (
    .addr(req_addr), .base(cfg_nc_base), .limit(cfg_nc_limit), .hit(nc_win_hit)
  );
  ird_window_match #(.ADDR_W(ADDR_W)) u_peer_win (
    .addr(req_addr), .base(cfg_peer_base), .limit(cfg_peer_limit), .hit(peer_hit)
  );

  for (genvar p = 0; p < PROT_N; p++) begin : g_prot
    ird_window_match #(.ADDR_W(ADDR_W)) u_win (
      .addr  (req_addr),
      .base  (cfg_prot_base[p*ADDR_W +: ADDR_W]),
      .limit (cfg_prot_limit[p*ADDR_W +: ADDR_W]),
      .hit   (prot_hits[p])
    );
  end

  for (genvar m = 0; m < MGMT_N; m++) begin : g_mgmt
    ird_window_match #(.ADDR_W(ADDR_W)) u_win (
      .addr  (req_addr),
      .base  (cfg_mgmt_base[m*ADDR_W +: ADDR_W]),
      .limit (cfg_mgmt_limit[m*ADDR_W +: ADDR_W]),
      .hit   (mgmt_hits[m])
    );
  end

  always_comb begin
    over_limit = (req_addr >= cfg_phys_limit);
    mem_hit    = low_hit || high_hit;
  end

  ird_classify #(.ADDR_W(ADDR_W)) u_classify (
    .addr       (req_addr),
    .is_io      (req_is_io),
    .is_write   (req_is_write),
    .over_limit (over_limit),
    .prot_hit   (|prot_hits),
    .mgmt_hit   (|mgmt_hits),
    .mem_hit    (mem_hit),
    .nc_hit     (nc_win_hit),
    .peer_hit   (peer_hit),
    .decision   (decision)
  );

  ird_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (decision),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (rsp_data)
  );

  assign rsp_target = rsp_data.target;
  assign rsp_noncoh = rsp_data.noncoh;

  AST_ERR_ABOVE_LIMIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid && req_ready && !req_is_io && (req_addr >= cfg_phys_limit)
    |=> rsp_target == TGT_ERROR); // R1
  AST_IO_TARGETS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid && req_ready && req_is_io
    |=> (rsp_target == TGT_VGA_IO) || (rsp_target == TGT_SUBTR)); // R4
  AST_WINDOWS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid && req_ready |-> cfg_tolm <= HIGH_BASE); // R5
  AST_NC_ONLY_MEM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid && rsp_noncoh |-> rsp_target == TGT_MEM); // R6
  AST_PEER_READ_REJECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid && req_ready && !req_is_io && !req_is_write
    |=> rsp_target != TGT_PEER); // R7

endmodule

// File: tb/test_inbound_route_decoder.sv
module test_inbound_route_decoder;
  import ird_pkg::*;

  localparam int AW = 40;
  localparam int PN = 2;
  localparam int MN = 2;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_is_io = 1'b0;
  logic          req_is_write = 1'b0;
  logic [AW-1:0] cfg_phys_limit, cfg_tolm, cfg_tohm;
  logic [AW-1:0] cfg_nc_base, cfg_nc_limit, cfg_peer_base, cfg_peer_limit;
  logic [PN*AW-1:0] cfg_prot_base, cfg_prot_limit;
  logic [MN*AW-1:0] cfg_mgmt_base, cfg_mgmt_limit;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [2:0]    rsp_target;
  logic          rsp_noncoh;

  int checks = 0;
  int failures = 0;
  int sent = 0;
  int received = 0;
  bit bp_on = 1'b0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  decision_t exp_q[$];
  string     tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  inbound_route_decoder #(.ADDR_W(AW), .PROT_N(PN), .MGMT_N(MN)) i_inbound_route_decoder (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_is_io(req_is_io), .req_is_write(req_is_write),
    .cfg_phys_limit(cfg_phys_limit), .cfg_tolm(cfg_tolm), .cfg_tohm(cfg_tohm),
    .cfg_nc_base(cfg_nc_base), .cfg_nc_limit(cfg_nc_limit),
    .cfg_peer_base(cfg_peer_base), .cfg_peer_limit(cfg_peer_limit),
    .cfg_prot_base(cfg_prot_base), .cfg_prot_limit(cfg_prot_limit),
    .cfg_mgmt_base(cfg_mgmt_base), .cfg_mgmt_limit(cfg_mgmt_limit),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_target(rsp_target), .rsp_noncoh(rsp_noncoh)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Backpressure: rsp_ready changes just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rsp_ready = bp_on ? (lfsr[0] | lfsr[3]) : 1'b1;
    end
  end

  // Monitor / scoreboard
  bit        prev_stall = 1'b0;
  decision_t held;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (prev_stall) begin
          check(rsp_target == held.target && rsp_noncoh == held.noncoh, "R10",
                "held result changed", {4'b0, rsp_target, rsp_noncoh},
                {4'b0, held.target, held.noncoh});
        end
        if (!rsp_ready) begin
          check(!req_ready, "R10", "req_ready while stalled", {7'b0, req_ready}, 8'h00);
          prev_stall = 1'b1;
          held = '{target: route_e'(rsp_target), noncoh: rsp_noncoh};
        end else begin
          prev_stall = 1'b0;
          if (exp_q.size() == 0) begin
            check(1'b0, "R10", "unexpected response", {5'b0, rsp_target}, 8'hFF);
          end else begin
            decision_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            received++;
            check(rsp_target == e.target, t, "target", {5'b0, rsp_target}, {5'b0, e.target});
            check(rsp_noncoh == e.noncoh, t, "noncoh", {7'b0, rsp_noncoh}, {7'b0, e.noncoh});
          end
        end
      end else begin
        prev_stall = 1'b0;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic send(input logic [AW-1:0] a, input bit io, input bit wr,
                      input route_e t, input bit nc, input string rq);
    req_addr = a;
    req_is_io = io;
    req_is_write = wr;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    exp_q.push_back('{target: t, noncoh: nc});
    tag_q.push_back(rq);
    sent++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    bp_on = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic base_config();
    cfg_phys_limit = 40'h10_0000_0000;
    cfg_tolm       = 40'h00_8000_0000;
    cfg_tohm       = 40'h02_0000_0000;
    cfg_nc_base    = 40'h01_8000_0000;
    cfg_nc_limit   = 40'h01_9000_0000;
    cfg_peer_base  = 40'h00_C000_0000;
    cfg_peer_limit = 40'h00_D000_0000;
    cfg_prot_base  = {40'h00_FED0_0000, 40'h00_FE00_0000};
    cfg_prot_limit = {40'h00_FED1_0000, 40'h00_FE10_0000};
    cfg_mgmt_base  = {40'h0, 40'h00_FED0_8000};
    cfg_mgmt_limit = {40'h0, 40'h00_FED0_9000};
  endtask

  initial begin
    base_config();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rsp_valid == 1'b0, "R11", "rsp_valid after reset", {7'b0, rsp_valid}, 8'h00);
    check(req_ready == 1'b1, "R11", "req_ready after reset", {7'b0, req_ready}, 8'h01);

    bp_on = 1'b1;
    // R5 / R9 low window
    send(40'h0000_1000, 0, 0, TGT_MEM, 0, "R5");
    send(40'h7FFF_FFFF, 0, 1, TGT_MEM, 0, "R9");
    send(40'h8000_0000, 0, 0, TGT_SUBTR, 0, "R9");
    // R3 legacy memory override
    send(40'h000A_0000, 0, 0, TGT_VGA_MEM, 0, "R3");
    send(40'h000B_FFFF, 0, 1, TGT_VGA_MEM, 0, "R3");
    send(40'h0009_FFFF, 0, 0, TGT_MEM, 0, "R3");
    send(40'h000C_0000, 0, 0, TGT_MEM, 0, "R3");
    // R5 / R6 high window and non-coherent sub-window
    send(40'h1_0000_0000, 0, 0, TGT_MEM, 0, "R5");
    send(40'h1_8000_0000, 0, 1, TGT_MEM, 1, "R6");
    send(40'h1_8FFF_FFFF, 0, 0, TGT_MEM, 1, "R6");
    send(40'h1_9000_0000, 0, 0, TGT_MEM, 0, "R6");
    send(40'h1_7FFF_FFFF, 0, 0, TGT_MEM, 0, "R6");
    send(40'h2_0000_0000, 0, 0, TGT_SUBTR, 0, "R9");
    // R8 / R1
    send(40'hF_FFFF_FFFF, 0, 0, TGT_SUBTR, 0, "R8");
    send(40'h10_0000_0000, 0, 1, TGT_ERROR, 0, "R1");
    send(40'hFF_FFFF_FFFF, 0, 0, TGT_ERROR, 0, "R1");
    // R4 legacy I/O, upper bits ignored, limit not applied
    send(40'h10_0000_03B0, 1, 0, TGT_VGA_IO, 0, "R4");
    send(40'h0000_03BB, 1, 1, TGT_VGA_IO, 0, "R4");
    send(40'h0000_03BC, 1, 0, TGT_SUBTR, 0, "R4");
    send(40'h0000_03AF, 1, 0, TGT_SUBTR, 0, "R4");
    send(40'h0000_03C0, 1, 0, TGT_VGA_IO, 0, "R4");
    send(40'h0000_03DF, 1, 1, TGT_VGA_IO, 0, "R4");
    send(40'h0000_03E0, 1, 0, TGT_SUBTR, 0, "R4");
    send(40'h0001_03C5, 1, 0, TGT_VGA_IO, 0, "R4");
    send(40'h0000_1000, 1, 0, TGT_SUBTR, 0, "R4");
    // R7 peer window
    send(40'hC000_1000, 0, 1, TGT_PEER, 0, "R7");
    send(40'hC000_1000, 0, 0, TGT_ABORT, 0, "R7");
    send(40'hCFFF_FFFF, 0, 1, TGT_PEER, 0, "R7");
    send(40'hD000_0000, 0, 1, TGT_SUBTR, 0, "R7");
    // R2 protected and management windows
    send(40'hFE00_0000, 0, 0, TGT_ABORT, 0, "R2");
    send(40'hFE0F_FFFF, 0, 1, TGT_ABORT, 0, "R2");
    send(40'hFED0_0004, 0, 0, TGT_ABORT, 0, "R2");
    send(40'hFED0_8000, 0, 0, TGT_SUBTR, 0, "R2");
    send(40'hFED0_9000, 0, 1, TGT_ABORT, 0, "R2");
    drain();

    // Phase 2: low limit lowered, low window and nc window disabled
    cfg_phys_limit = 40'h1_0000_0000;
    cfg_tolm       = 40'h0;
    cfg_nc_limit   = cfg_nc_base;
    @(negedge clk);
    bp_on = 1'b1;
    send(40'h1_8000_0000, 0, 0, TGT_ERROR, 0, "R1");
    send(40'h0000_1000, 0, 0, TGT_SUBTR, 0, "R9");
    send(40'h000A_8000, 0, 0, TGT_VGA_MEM, 0, "R3");
    drain();
    cfg_phys_limit = 40'h10_0000_0000;
    @(negedge clk);
    bp_on = 1'b1;
    send(40'h1_8000_0000, 0, 0, TGT_MEM, 0, "R9");
    drain();

    // Phase 3: protected window over the legacy range takes priority
    base_config();
    cfg_prot_base[AW +: AW]  = 40'h000A_0000;
    cfg_prot_limit[AW +: AW] = 40'h000B_0000;
    @(negedge clk);
    bp_on = 1'b1;
    send(40'h000A_8000, 0, 0, TGT_ABORT, 0, "R2");
    send(40'h000B_8000, 0, 0, TGT_VGA_MEM, 0, "R3");
    send(40'h000B_0000, 0, 1, TGT_VGA_MEM, 0, "R3");
    drain();

    check(received == sent, "R10", "response count", received[7:0], sent[7:0]);
    done = 1'b1;
    finish_run();
  end

endmodule